// File: doc/BRIEF.md
# Hex Text Record Loader

This block sits behind a serial receiver and turns a stream of ASCII characters into loader records. A record opens with a colon. Pairs of hexadecimal digits follow it, and each pair gives one byte. The bytes are, in order: the data byte count, a 16-bit load address, a record type, the data bytes, and a checksum byte. A carriage return or a line feed closes the record. The block decodes the record into working registers and keeps a running 8-bit sum. The loader operation is raised only when the terminating line end arrives and the sum checks out.

Each character that the block accepts is echoed on the transmit stream. A status character follows the echo when a record completes or is abandoned. The status is '.' for a good record and 'X' for a rejected one. Echo and status bytes pass through a small queue. If the transmitter stalls, the queue fills and the receive side is held off through `rx_ready`, so no character is lost.

Both streams are valid/ready. An input character is taken on a clock edge where `rx_valid` and `rx_ready` are both high. While `tx_valid` is high and `tx_ready` is low, `tx_byte` stays unchanged. The decoded record is valid during the single cycle in which `rec_exec` is high. Flash programming happens downstream of this block.

Top module: `hexrec_loader`

## Requirements
- R1: Every accepted character is echoed on `tx_byte` in the order it arrived. No character is duplicated or dropped.
- R2: While the block waits for a colon (0x3A), any other character is echoed only. It produces no status byte and no `rec_exec`.
- R3: The record layout is: colon, count (1 byte), address (2 bytes, high byte first), type (1 byte), data (count bytes), checksum (1 byte), then CR (0x0D) or LF (0x0A). Each byte is two hex digits, high nibble first. The digits 0-9, A-F and a-f are accepted.
- R4: A record is valid when the 8-bit sum of every byte from the count through the checksum is zero. For a valid record, `rec_exec` pulses for exactly one cycle after the line end is accepted, and '.' (0x2E) is queued directly after the echo of that line end.
- R5: If the checksum does not sum to zero, 'X' (0x58) is queued after the echo of the line end. `rec_exec` stays low.
- R6: A count above 32 aborts the record once the second count digit is accepted. 'X' follows that digit's echo, and the block returns to waiting for a colon. A count of exactly 32 is accepted.
- R7: A non-hex character in any hex field, or a character other than CR or LF after the checksum, aborts the record. 'X' follows that character's echo, and the block waits for a colon again.
- R8: `rec_type` carries the raw type byte. `rec_kind` is 0 for type 0x00 (data), 1 for type 0x01 (end of file), and 2 for any other type (command).
- R9: During `rec_exec`, the following are valid: `rec_count`, `rec_addr`, and `rec_data`, where data byte i is at bits [8i+7:8i]. Data bytes at or beyond the count read as zero.
- R10: While stalled, `tx_valid` stays high and `tx_byte` stays stable until `tx_ready` is high. `rx_ready` is low whenever the queue has fewer than two free slots or a status byte is waiting to be queued.
- R11: After reset: `tx_valid` is 0, `rec_exec` is 0 and `rx_ready` is 1.
- R12: A record with a count of zero goes straight from the type byte to the checksum and is valid when its sum is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_byte | input | 8 | Received ASCII character |
| rx_valid | input | 1 | Character on `rx_byte` is offered |
| rx_ready | output | 1 | Block can take a character |
| tx_byte | output | 8 | Echo or status character |
| tx_valid | output | 1 | `tx_byte` holds a character |
| tx_ready | input | 1 | Transmitter takes `tx_byte` |
| rec_exec | output | 1 | One-cycle strobe for a valid complete record |
| rec_kind | output | 2 | 0 data, 1 end of file, 2 command |
| rec_type | output | 8 | Raw record type byte |
| rec_addr | output | 16 | Record load address |
| rec_count | output | 6 | Number of data bytes |
| rec_data | output | 256 | Data bytes, byte i at bits [8i+7:8i] |

## Verification
A parser that loses track of its field position shows up within one record. The status character appears after the wrong echo, or a strobe fires with a shifted address or shifted data bytes. The bench therefore compares the whole transmitted character stream against an independently built expectation, which places every status byte exactly. A corrupted running sum or count limit shows up as a flipped '.'/'X' at the line end of the same record. A queue that loses or repeats an entry under stall shows up in the stream comparison as soon as the queue drains.

// File: rtl/hexrec_pkg.sv
package hexrec_pkg;

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_CNT,
    PS_ADDR,
    PS_TYPE,
    PS_DATA,
    PS_CSUM,
    PS_EOL
  } pstate_t;

  localparam logic [1:0] KIND_DATA = 2'd0;
  localparam logic [1:0] KIND_EOF  = 2'd1;
  localparam logic [1:0] KIND_CMD  = 2'd2;

  localparam logic [7:0] CH_COLON = 8'h3A;
  localparam logic [7:0] CH_CR    = 8'h0D;
  localparam logic [7:0] CH_LF    = 8'h0A;
  localparam logic [7:0] CH_OK    = 8'h2E;
  localparam logic [7:0] CH_BAD   = 8'h58;

endpackage

// File: rtl/hexrec_digit.sv
module hexrec_digit (
  input  logic [7:0] ch,
  output logic       ok,
  output logic [3:0] val
);
  always_comb begin
    ok  = 1'b1;
    val = 4'd0;
    if (ch >= 8'h30 && ch <= 8'h39) begin
      val = 4'(ch - 8'h30);
    end else if (ch >= 8'h41 && ch <= 8'h46) begin
      val = 4'(ch - 8'h37);
    end else if (ch >= 8'h61 && ch <= 8'h66) begin
      val = 4'(ch - 8'h57);
    end else begin
      ok = 1'b0;
    end
  end
endmodule

// File: rtl/hexrec_fifo.sv
module hexrec_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  assign dout = mem[rp];

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> (count < CW'(DEPTH)));
  p_no_underflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));
endmodule

// File: rtl/hexrec_parser.sv
module hexrec_parser
  import hexrec_pkg::*;
#(
  parameter int MAX_BYTES = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              acc,
  input  logic [7:0]                        ch,
  input  logic                              dig_ok,
  input  logic [3:0]                        dig_val,
  output logic                              stat_pend,
  output logic [7:0]                        stat_char,
  output logic                              rec_exec,
  output logic [7:0]                        rec_type,
  output logic [15:0]                       rec_addr,
  output logic [$clog2(MAX_BYTES+1)-1:0]    rec_count,
  output logic [MAX_BYTES*8-1:0]            rec_data
);
  localparam int CNTW = $clog2(MAX_BYTES + 1);
  localparam int IDXW = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

  pstate_t              state;
  logic                 hi;
  logic [3:0]           nib;
  logic [7:0]           sum;
  logic [CNTW-1:0]      idx;
  logic [MAX_BYTES-1:0][7:0] dbuf;
  logic [7:0]           byte_w;

  assign byte_w   = {nib, dig_val};
  assign rec_data = dbuf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= PS_IDLE;
      hi        <= 1'b0;
      nib       <= '0;
      sum       <= '0;
      idx       <= '0;
      dbuf      <= '0;
      rec_count <= '0;
      rec_addr  <= '0;
      rec_type  <= '0;
      stat_pend <= 1'b0;
      stat_char <= CH_OK;
      rec_exec  <= 1'b0;
    end else begin
      stat_pend <= 1'b0;
      rec_exec  <= 1'b0;
      if (acc) begin
        case (state)
          PS_IDLE: begin
            if (ch == CH_COLON) begin
              state     <= PS_CNT;
              hi        <= 1'b0;
              sum       <= '0;
              idx       <= '0;
              dbuf      <= '0;
              rec_count <= '0;
              rec_addr  <= '0;
              rec_type  <= '0;
            end
          end
          PS_EOL: begin
            state     <= PS_IDLE;
            stat_pend <= 1'b1;
            if ((ch == CH_CR || ch == CH_LF) && sum == 8'd0) begin
              stat_char <= CH_OK;
              rec_exec  <= 1'b1;
            end else begin
              stat_char <= CH_BAD;
            end
          end
          default: begin
            if (!dig_ok) begin
              state     <= PS_IDLE;
              stat_pend <= 1'b1;
              stat_char <= CH_BAD;
            end else if (!hi) begin
              nib <= dig_val;
              hi  <= 1'b1;
            end else begin
              hi  <= 1'b0;
              sum <= sum + byte_w;
              case (state)
                PS_CNT: begin
                  if (int'(byte_w) > MAX_BYTES) begin
                    state     <= PS_IDLE;
                    stat_pend <= 1'b1;
                    stat_char <= CH_BAD;
                  end else begin
                    rec_count <= CNTW'(byte_w);
                    idx       <= '0;
                    state     <= PS_ADDR;
                  end
                end
                PS_ADDR: begin
                  if (idx == '0) begin
                    rec_addr[15:8] <= byte_w;
                    idx            <= CNTW'(1);
                  end else begin
                    rec_addr[7:0] <= byte_w;
                    state         <= PS_TYPE;
                  end
                end
                PS_TYPE: begin
                  rec_type <= byte_w;
                  idx      <= '0;
                  state    <= (rec_count == '0) ? PS_CSUM : PS_DATA;
                end
                PS_DATA: begin
                  dbuf[idx[IDXW-1:0]] <= byte_w;
                  idx <= idx + 1'b1;
                  if (idx == rec_count - 1'b1) state <= PS_CSUM;
                end
                PS_CSUM: state <= PS_EOL;
                default: state <= PS_IDLE;
              endcase
            end
          end
        endcase
      end
    end
  end

  p_exec_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rec_exec |=> !rec_exec);
  p_exec_ok_char_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rec_exec |-> (stat_pend && stat_char == CH_OK));
  p_count_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rec_exec |-> (int'(rec_count) <= MAX_BYTES));
  p_abort_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_pend && stat_char == CH_BAD) |-> (state == PS_IDLE));
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_IDLE && acc && ch != CH_COLON) |=> (!stat_pend && !rec_exec));
endmodule

// File: rtl/hexrec_loader.sv
module hexrec_loader
  import hexrec_pkg::*;
#(
  parameter int MAX_BYTES  = 32,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [7:0]             rx_byte,
  input  logic                   rx_valid,
  output logic                   rx_ready,
  output logic [7:0]             tx_byte,
  output logic                   tx_valid,
  input  logic                   tx_ready,
  output logic                   rec_exec,
  output logic [1:0]             rec_kind,
  output logic [7:0]             rec_type,
  output logic [15:0]            rec_addr,
  output logic [5:0]             rec_count,
  output logic [MAX_BYTES*8-1:0] rec_data
);
  localparam int CNTW = $clog2(MAX_BYTES + 1);
  localparam int FCW  = $clog2(FIFO_DEPTH + 1);

  logic            acc;
  logic            dig_ok;
  logic [3:0]      dig_val;
  logic            stat_pend;
  logic [7:0]      stat_char;
  logic [CNTW-1:0] cnt_w;
  logic [FCW-1:0]  fcount;
  logic            push, pop;
  logic [7:0]      push_d;

  assign rx_ready = (int'(fcount) + 2 <= FIFO_DEPTH) && !stat_pend;
  assign acc      = rx_valid && rx_ready;
  assign push     = acc || stat_pend;
  assign push_d   = stat_pend ? stat_char : rx_byte;
  assign tx_valid = (fcount != '0);
  assign pop      = tx_valid && tx_ready;

  hexrec_digit u_digit (
    .ch  (rx_byte),
    .ok  (dig_ok),
    .val (dig_val)
  );

  hexrec_parser #(.MAX_BYTES(MAX_BYTES)) u_parser (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (acc),
    .ch        (rx_byte),
    .dig_ok    (dig_ok),
    .dig_val   (dig_val),
    .stat_pend (stat_pend),
    .stat_char (stat_char),
    .rec_exec  (rec_exec),
    .rec_type  (rec_type),
    .rec_addr  (rec_addr),
    .rec_count (cnt_w),
    .rec_data  (rec_data)
  );

  hexrec_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .din   (push_d),
    .pop   (pop),
    .dout  (tx_byte),
    .count (fcount)
  );

  assign rec_count = 6'(cnt_w);
  assign rec_kind  = (rec_type == 8'h00) ? KIND_DATA :
                     (rec_type == 8'h01) ? KIND_EOF  : KIND_CMD;

  p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));
  p_exec_after_eol_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rec_exec |-> $past(rx_valid && rx_ready && (rx_byte == CH_CR || rx_byte == CH_LF)));
  p_status_queued_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stat_pend |-> !(rx_valid && rx_ready));
endmodule

// File: tb/tb_hexrec_loader.sv
module tb_hexrec_loader;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   rx_byte = 8'h00;
  logic         rx_valid = 1'b0;
  logic         rx_ready;
  logic [7:0]   tx_byte;
  logic         tx_valid;
  logic         tx_ready = 1'b1;
  logic         rec_exec;
  logic [1:0]   rec_kind;
  logic [7:0]   rec_type;
  logic [15:0]  rec_addr;
  logic [5:0]   rec_count;
  logic [255:0] rec_data;

  int checks = 0;
  int errors = 0;
  logic [7:0] outq [0:4095];
  int out_n = 0;
  int base = 0;
  int ex_n = 0;
  logic [5:0]   ex_cnt;
  logic [15:0]  ex_addr;
  logic [1:0]   ex_kind;
  logic [7:0]   ex_type;
  logic [255:0] ex_data;
  logic         prev_stall = 1'b0;
  logic [7:0]   prev_byte = 8'h00;
  int stall_err = 0;
  logic [7:0] dbuf [0:63];
  bit done = 1'b0;

  always #10 clk = ~clk;

  hexrec_loader dut (
    .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready), .rec_exec(rec_exec),
    .rec_kind(rec_kind), .rec_type(rec_type), .rec_addr(rec_addr), .rec_count(rec_count),
    .rec_data(rec_data)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall && (!tx_valid || tx_byte != prev_byte)) stall_err++;
      prev_stall = tx_valid && !tx_ready;
      prev_byte  = tx_byte;
      if (tx_valid && tx_ready) begin
        outq[out_n % 4096] = tx_byte;
        out_n++;
      end
      if (rec_exec) begin
        ex_n++;
        ex_cnt  = rec_count;
        ex_addr = rec_addr;
        ex_kind = rec_kind;
        ex_type = rec_type;
        ex_data = rec_data;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] c);
    @(posedge clk); #1;
    rx_byte  = c;
    rx_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (rx_ready) break;
    end
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send(s[i]);
  endtask

  task automatic drain();
    repeat (30) @(posedge clk);
  endtask

  function automatic string mk_rec(input int cnt, input int addr, input int typ,
                                   input int bad, input bit lower);
    string s;
    logic [7:0] sm;
    logic [7:0] b [0:67];
    int n;
    b[0] = 8'(cnt); b[1] = 8'(addr >> 8); b[2] = 8'(addr); b[3] = 8'(typ);
    for (int i = 0; i < cnt; i++) b[4+i] = dbuf[i];
    sm = 8'h00;
    for (int i = 0; i < cnt + 4; i++) sm = sm + b[i];
    n = cnt + 4;
    b[n] = 8'(8'h00 - sm + 8'(bad));
    s = ":";
    for (int i = 0; i <= n; i++)
      s = {s, lower ? $sformatf("%02x", b[i]) : $sformatf("%02X", b[i])};
    return s;
  endfunction

  task automatic check_stream(input string exp, input string tag);
    int got;
    int bad;
    got = out_n - base;
    check(got == exp.len(), {tag, " stream length"}, 64'(got), 64'(exp.len()));
    bad = -1;
    for (int i = 0; i < exp.len() && i < got; i++)
      if (bad < 0 && outq[(base + i) % 4096] != exp[i]) bad = i;
    if (bad >= 0)
      check(1'b0, {tag, " stream byte"}, 64'(outq[(base + bad) % 4096]), 64'(exp[bad]));
    else
      check(1'b1, {tag, " stream byte"}, 0, 0);
    base = out_n;
  endtask

  task automatic t_reset();
    check(tx_valid == 1'b0, "R11 tx_valid", 64'(tx_valid), 0);
    check(rec_exec == 1'b0, "R11 rec_exec", 64'(rec_exec), 0);
    check(rx_ready == 1'b1, "R11 rx_ready", 64'(rx_ready), 1);
  endtask

  task automatic t_noise();
    int e0;
    e0 = ex_n;
    send_str("ab\015?");
    drain();
    check_stream("ab\015?", "R2 R1 noise echoed only");
    check(ex_n == e0, "R2 no exec on noise", 64'(ex_n), 64'(e0));
  endtask

  task automatic t_data_rec();
    string l;
    int e0;
    e0 = ex_n;
    dbuf[0] = 8'h11; dbuf[1] = 8'h22; dbuf[2] = 8'hA5; dbuf[3] = 8'hFF;
    l = mk_rec(4, 16'h1234, 8'h00, 0, 1'b0);
    send_str({l, "\015\012"});
    drain();
    check_stream({l, "\015.\012"}, "R4 R3 good record status");
    check(ex_n == e0 + 1, "R4 one exec", 64'(ex_n), 64'(e0 + 1));
    check(ex_addr == 16'h1234, "R9 R3 address", 64'(ex_addr), 64'h1234);
    check(ex_cnt == 6'd4, "R9 count", 64'(ex_cnt), 4);
    check(ex_kind == 2'd0, "R8 data kind", 64'(ex_kind), 0);
    check(ex_data[31:0] == 32'hFFA52211, "R9 data bytes", 64'(ex_data[31:0]), 64'hFFA52211);
    check(ex_data[255:32] == '0, "R9 bytes beyond count zero", 64'(ex_data[63:32]), 0);
  endtask

  task automatic t_lower();
    string l;
    int e0;
    e0 = ex_n;
    dbuf[0] = 8'hBE; dbuf[1] = 8'hEF;
    l = mk_rec(2, 16'hABCD, 8'h00, 0, 1'b1);
    send_str({l, "\012"});
    drain();
    check_stream({l, "\012."}, "R3 lowercase digits with LF");
    check(ex_n == e0 + 1 && ex_data[15:0] == 16'hEFBE, "R3 lowercase data",
          64'(ex_data[15:0]), 64'hEFBE);
  endtask

  task automatic t_bad_sum();
    string l;
    int e0;
    e0 = ex_n;
    dbuf[0] = 8'h5A;
    l = mk_rec(1, 16'h0040, 8'h00, 1, 1'b0);
    send_str({l, "\015"});
    drain();
    check_stream({l, "\015X"}, "R5 checksum mismatch");
    check(ex_n == e0, "R5 no exec", 64'(ex_n), 64'(e0));
  endtask

  task automatic t_count_limit();
    string l;
    int e0;
    e0 = ex_n;
    send_str(":2100000000\015");
    drain();
    check_stream(":21X00000000\015", "R6 count 33 aborts");
    check(ex_n == e0, "R6 no exec on 33", 64'(ex_n), 64'(e0));
    for (int i = 0; i < 32; i++) dbuf[i] = 8'(i * 7 + 1);
    l = mk_rec(32, 16'hFFF0, 8'h05, 0, 1'b0);
    send_str({l, "\015"});
    drain();
    check_stream({l, "\015."}, "R6 count 32 accepted");
    check(ex_n == e0 + 1 && ex_cnt == 6'd32, "R6 count 32 exec", 64'(ex_cnt), 32);
    check(ex_data[255:248] == 8'(31 * 7 + 1), "R9 last data byte",
          64'(ex_data[255:248]), 64'(8'(31 * 7 + 1)));
    check(ex_kind == 2'd2 && ex_type == 8'h05, "R8 command kind", 64'(ex_kind), 2);
  endtask

  task automatic t_bad_char();
    string l;
    int e0;
    e0 = ex_n;
    send_str(":02G1\015");
    drain();
    check_stream(":02GX1\015", "R7 non-hex in address");
    dbuf[0] = 8'h01; dbuf[1] = 8'h02;
    l = mk_rec(2, 16'h0100, 8'h00, 0, 1'b0);
    send_str({l, "Z\015"});
    drain();
    check_stream({l, "ZX\015"}, "R7 junk after checksum");
    check(ex_n == e0, "R7 no exec", 64'(ex_n), 64'(e0));
  endtask

  task automatic t_eof();
    int e0;
    e0 = ex_n;
    send_str(":00000001FF\015");
    drain();
    check_stream(":00000001FF\015.", "R12 zero-count record");
    check(ex_n == e0 + 1 && ex_cnt == 6'd0, "R12 exec count 0", 64'(ex_cnt), 0);
    check(ex_kind == 2'd1, "R8 eof kind", 64'(ex_kind), 1);
  endtask

  task automatic t_backpressure();
    string l;
    int e0;
    e0 = ex_n;
    for (int i = 0; i < 6; i++) dbuf[i] = 8'(8'h30 + i);
    l = mk_rec(6, 16'h2000, 8'h00, 0, 1'b0);
    tx_ready = 1'b0;
    fork
      send_str({l, "\015"});
      begin
        repeat (60) @(negedge clk);
        check(rx_ready == 1'b0, "R10 rx_ready low when queue full", 64'(rx_ready), 0);
        @(posedge clk); #1;
        tx_ready = 1'b1;
      end
    join
    drain();
    check_stream({l, "\015."}, "R10 R1 no loss under stall");
    check(ex_n == e0 + 1, "R10 exec after stall", 64'(ex_n), 64'(e0 + 1));
    check(stall_err == 0, "R10 tx held while stalled", 64'(stall_err), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    t_noise();
    t_data_rec();
    t_lower();
    t_bad_sum();
    t_count_limit();
    t_bad_char();
    t_eof();
    t_backpressure();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule